// File: doc/BRIEF.md
# External Interrupt Edge Detection Unit

The unit monitors four asynchronous interrupt pins. For each pin it records a pending request in a sticky flag when the pin makes a qualifying transition. Pins 0 and 1 are fixed to falling-edge sensing. Pins 2 and 3 each take a two-bit sense field from a write-only configuration register. That field can disable detection or pick the falling edge, the rising edge or both edges.

A global enable bit decides whether pending flags reach the processor as a single level-sensitive request. Several strobes and a write port manage the unit:

- The take strobe marks the processor entering its handler and clears the enable.
- The return strobe sets the enable again.
- Software clears individual flags through the small write port, using a write-zero-to-clear rule.

Each pin is first passed through a two-stage synchronizer. An edge is found by comparing the synchronized level with its level one cycle earlier.

Top module: `ext_irq_edge_unit`

## Requirements
- R1: A flag for pin 0 or pin 1 is set by a high-to-low transition of that pin. A low-to-high transition never sets it.
- R2: The sense register is at address 0. Bits 1:0 control pin 2 and bits 3:2 control pin 3. The codes are 00 none, 01 falling, 10 rising and 11 both. The pin's flag is set only by the transitions its code selects.
- R3: After reset the flags are 0000, the enable is 0, `irq_o` is 0 and the sense register is 0000, so pins 2 and 3 set no flag until it is written.
- R4: `flags_o[i]` reports the request for pin i (1 means pending). A set flag stays set until software clears it.
- R5: A write to address 1 clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R6: When a qualifying edge and a clearing write reach a flag in the same cycle, the flag stays set.
- R7: A take pulse makes `ien_o` 0 from the next cycle. A return pulse makes it 1 from the next cycle. If both arrive in the same cycle, take wins.
- R8: `irq_o` is 1 exactly when `ien_o` is 1 and at least one flag is 1.
- R9: Flags keep their value while the enable is 0. `irq_o` is raised for them once the enable returns to 1.
- R10: Writing a new sense code does not by itself set any flag.
- R11: A pin transition applied between two clock edges is first visible in `flags_o` after the third following rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Asynchronous interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 sense register, 1 flags |
| wr_data_i | input | 4 | Write data |
| take_i | input | 1 | Interrupt taken strobe, clears enable |
| ret_i | input | 1 | Return-from-interrupt strobe, sets enable |
| flags_o | output | 4 | Pending request flags |
| ien_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Request to the processor |

## Verification
The hardest situation to reach is a pin edge that lands in the same cycle as a software write clearing that pin's flag. The edge has to cross the synchronizer and history stages before it counts. The stimulus therefore drops the pin and waits exactly two clock edges. It then issues the clearing write for one cycle, so the detected edge and the write meet on the same register update. A repeat of the same write with no edge confirms that the clear itself works.

// File: rtl/irq_edge_pkg.sv
// Package: shared types and register addresses for the external interrupt
// edge detection unit.
package irq_edge_pkg;

    // Edge sense selection, one code per programmable pin.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int ADDR_W = 2;

    // Write-port address map.
    localparam logic [ADDR_W-1:0] REG_EDGE_SEL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_FLAGS    = 2'd1;

endpackage

// File: rtl/irq_pin_sync.sv
// Module: irq_pin_sync
// Brings one asynchronous pin into the clock domain through STAGES flops.
// It also keeps the synchronized level from one cycle earlier, for edge
// comparison.
// Assumes STAGES >= 2. RST_VAL is the idle level of the pin.
module irq_pin_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic cur_o,
    output logic prev_o
);

    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    // Shift the pin through the synchronizer and record the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            hist_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            hist_q  <= chain_q[STAGES-1];
        end
    end

    assign cur_o  = chain_q[STAGES-1];
    assign prev_o = hist_q;

endmodule

// File: rtl/irq_edge_qual.sv
// Module: irq_edge_qual
// Decides, from the current and previous synchronized levels, whether the
// transition matches the selected sense mode. Purely combinational.
module irq_edge_qual
    import irq_edge_pkg::*;
(
    input  edge_mode_e mode_i,
    input  logic       cur_i,
    input  logic       prev_i,
    output logic       hit_o
);

    logic rise;
    logic fall;

    assign rise = cur_i & ~prev_i;
    assign fall = ~cur_i & prev_i;

    // Select which transition counts for this mode.
    always_comb begin
        unique case (mode_i)
            EDGE_NONE: hit_o = 1'b0;
            EDGE_FALL: hit_o = fall;
            EDGE_RISE: hit_o = rise;
            EDGE_BOTH: hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_flag_reg.sv
// Module: irq_flag_reg
// Sticky request flag. A set request wins over a clear in the same cycle,
// so no edge is lost to a racing software clear.
module irq_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Hold the pending request: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

endmodule

// File: rtl/irq_enable_ctl.sv
// Module: irq_enable_ctl
// Global enable bit and the request gate. A take strobe clears the enable
// and wins over a simultaneous return strobe. The enable resets to 0.
module irq_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic ret_i,
    input  logic pending_i,
    output logic ien_o,
    output logic irq_o
);

    // Track the global enable across handler entry and exit.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_o <= 1'b0;
        else if (take_i) ien_o <= 1'b0;
        else if (ret_i)  ien_o <= 1'b1;
    end

    assign irq_o = ien_o & pending_i;

endmodule

// File: rtl/ext_irq_edge_unit.sv
// Module: ext_irq_edge_unit
// Top of the external interrupt edge detection unit.
// - The first N_FIXED pins sense falling edges only.
// - The remaining pins each take a 2-bit sense code from a write-only
//   register.
// - Flags are sticky and cleared by writing 0 to their bit.
// Assumes N_FIXED < N_PINS and that all inputs share clk, except pin_i.
module ext_irq_edge_unit
    import irq_edge_pkg::*;
#(
    parameter int N_PINS      = 4,
    parameter int N_FIXED     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int N_PROG     = N_PINS - N_FIXED,
    localparam int SEL_W      = 2 * N_PROG,
    localparam int DATA_W     = (SEL_W > N_PINS) ? SEL_W : N_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    input  logic              ret_i,
    output logic [N_PINS-1:0] flags_o,
    output logic              ien_o,
    output logic              irq_o
);

    logic [SEL_W-1:0]  sel_q;
    logic [N_PINS-1:0] hit;
    logic [N_PINS-1:0] clr;
    logic              sel_wr;
    logic              flag_wr;

    assign sel_wr  = wr_en_i && (wr_addr_i == REG_EDGE_SEL);
    assign flag_wr = wr_en_i && (wr_addr_i == REG_FLAGS);

    // Hold the write-only sense register; it resets to "no detection".
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= wr_data_i[SEL_W-1:0];
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic       cur;
        logic       prev;
        edge_mode_e mode;

        irq_pin_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[i]),
            .cur_o  (cur),
            .prev_o (prev)
        );

        if (i < N_FIXED) begin : g_fixed
            assign mode = EDGE_FALL;
        end else begin : g_prog
            assign mode = edge_mode_e'(sel_q[2*(i-N_FIXED) +: 2]);
        end

        irq_edge_qual u_qual (
            .mode_i (mode),
            .cur_i  (cur),
            .prev_i (prev),
            .hit_o  (hit[i])
        );

        assign clr[i] = flag_wr && !wr_data_i[i];

        irq_flag_reg u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (hit[i]),
            .clr_i  (clr[i]),
            .flag_o (flags_o[i])
        );
    end

    irq_enable_ctl u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take_i),
        .ret_i     (ret_i),
        .pending_i (|flags_o),
        .ien_o     (ien_o),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/irq_edge_chk.sv
// Module: irq_edge_chk
// Protocol checker, bound to ext_irq_edge_unit. It observes ports only.
module irq_edge_chk
    import irq_edge_pkg::*;
#(
    parameter int N_PINS = 4,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              take_i,
    input logic              ret_i,
    input logic [N_PINS-1:0] flags_o,
    input logic              ien_o,
    input logic              irq_o
);

    AST_TAKE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n) take_i |=> !ien_o); // R7
    AST_RET_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n) (ret_i && !take_i) |=> ien_o); // R7
    AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!take_i && !ret_i) |=> $stable(ien_o)); // R7
    AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !ien_o |-> !irq_o); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (flags_o != '0)); // R8

    for (genvar i = 0; i < N_PINS; i++) begin : g_flag
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !(wr_en_i && wr_addr_i == REG_FLAGS && !wr_data_i[i])) |=> flags_o[i]); // R4
    end

endmodule

bind ext_irq_edge_unit irq_edge_chk #(
    .N_PINS (N_PINS),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take_i),
    .ret_i     (ret_i),
    .flags_o   (flags_o),
    .ien_o     (ien_o),
    .irq_o     (irq_o)
);

// File: tb/sim_ext_irq_edge_unit.sv
module sim_ext_irq_edge_unit;
    import irq_edge_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pin;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [3:0] wr_data;
    logic       take;
    logic       ret;
    logic [3:0] flags;
    logic       ien;
    logic       irq;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    ext_irq_edge_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .take_i    (take),
        .ret_i     (ret),
        .flags_o   (flags),
        .ien_o     (ien),
        .irq_o     (irq)
    );

    // Fields: [15:12] sense code, [11:8] pins before, [7:4] pins after, [3:0] expected flags
    localparam logic [15:0] VEC [10] = '{
        16'h0F03, 16'h00F0, 16'h5F0F, 16'h50F0, 16'hA0FC,
        16'hAF03, 16'hFF0F, 16'hF0FC, 16'h948C, 16'h6480
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] addr, input logic [3:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_take(input logic t, input logic r);
        take = t; ret = r;
        step(1);
        take = 1'b0; ret = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pin = 4'hF; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        take = 1'b0; ret = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R3", "flags after reset", flags, 4'h0);
        check("R3", "ien after reset", ien, 1'b0);
        check("R3", "irq after reset", irq, 1'b0);
        // Sense register is zero: pins 2,3 must ignore a fall, pins 0,1 take it
        pin = 4'h0; step(5);
        check("R3", "pins 2,3 idle after reset", flags, 4'h3);
        pin = 4'hF; step(5);
        wr(REG_FLAGS, 4'h0);
        pulse_take(1'b0, 1'b1);
        check("R7", "return sets enable", ien, 1'b1);

        // Table walk over sense codes and pin transitions
        for (int k = 0; k < 10; k++) begin
            wr(REG_EDGE_SEL, VEC[k][15:12]);
            pin = VEC[k][11:8]; step(5);
            wr(REG_FLAGS, 4'h0);
            pin = VEC[k][7:4]; step(5);
            check("R1/R2", $sformatf("vector %0d flags", k), flags, VEC[k][3:0]);
            check("R8", $sformatf("vector %0d irq", k), irq, |VEC[k][3:0]);
            wr(REG_FLAGS, 4'h0);
        end

        // R11 latency: pin 0 falls, flag appears after third edge
        pin = 4'hF; step(5); wr(REG_FLAGS, 4'h0);
        pin = 4'hE; step(2);
        check("R11", "flag not before third edge", flags[0], 1'b0);
        step(1);
        check("R11", "flag after third edge", flags[0], 1'b1);

        // R5 write-zero-to-clear, ones keep
        wr(REG_FLAGS, 4'hF);
        check("R5", "ones leave flags", flags, 4'h1);
        pin = 4'hC; step(3);
        check("R4", "second flag set", flags, 4'h3);
        wr(REG_FLAGS, 4'h1);
        check("R5", "selective clear", flags, 4'h1);

        // R6 edge meets clear in the same cycle
        pin = 4'hF; step(5);
        check("R4", "flag held across rise", flags, 4'h1);
        pin = 4'hE; step(2);
        wr(REG_FLAGS, 4'h0);
        check("R6", "edge beats clear", flags, 4'h1);
        wr(REG_FLAGS, 4'h0);
        check("R5", "clear without edge", flags, 4'h0);

        // R10 sense change alone sets nothing
        pin = 4'hF; step(5);
        wr(REG_EDGE_SEL, 4'h0);
        pin = 4'hB; step(5);
        wr(REG_FLAGS, 4'h0);
        wr(REG_EDGE_SEL, 4'hF); step(5);
        check("R10", "mode write sets no flag", flags, 4'h0);
        pin = 4'hF; step(3);
        check("R2", "pin 2 both-edge rise", flags, 4'h4);

        // R9 flags kept while disabled
        check("R8", "irq with flag and enable", irq, 1'b1);
        pulse_take(1'b1, 1'b0);
        check("R7", "take clears enable", ien, 1'b0);
        check("R8", "irq off when disabled", irq, 1'b0);
        step(10);
        check("R9", "flag kept while disabled", flags, 4'h4);
        pulse_take(1'b0, 1'b1);
        check("R9", "irq delivered after return", irq, 1'b1);
        pulse_take(1'b1, 1'b1);
        check("R7", "take wins over return", ien, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule